// File: doc/BRIEF.md
# Dirty-Rectangle Window Flush Controller

This controller refreshes one damaged region of a 178 x 128 grey-scale panel whose frame memory packs three pixels into each byte. A caller presents a rectangle as two inclusive lower corners and two exclusive upper corners, together with a one-cycle `start` pulse. The block widens the rectangle horizontally to whole byte groups: the left edge moves down and the right edge moves up to a multiple of three pixels. It then emits the column-window command, the row-window command and the memory-write command on a byte-wide command/data output. After that it forwards the packed pixel bytes of the window, in order, from a byte source.

Both the output and the source use a valid/ready handshake. The output carries a flag that selects between command (0) and parameter/data (1), as the panel's A0 line does. A request is dropped without effect while the panel is inactive or a flush is already running. A rectangle that is empty or reaches past the panel is refused with a one-cycle error pulse. The block does no damage merging, colour conversion or serial shifting.

The state machine has seven states: `ST_IDLE`, `ST_COL_CMD`, `ST_COL_ARG`, `ST_ROW_CMD`, `ST_ROW_ARG`, `ST_MEM_CMD` and `ST_STREAM`. Its transitions are:
- idle to column command, on an accepted request;
- column command to column arguments, and row command to row arguments, on a command transfer;
- column arguments to row command, and row arguments to memory command, on the fourth argument transfer;
- memory command to stream, on its transfer;
- stream back to idle, on the transfer of the last data byte.

Top module: `rect_flush_ctrl`

## Requirements
- R1: After reset `busy`, `reject`, `done`, `out_valid` and `src_ready` are all 0.
- R2: A `start` while `panel_on` is 0 has no effect: no output transfer, no `reject`, `busy` stays 0.
- R3: A `start` with `panel_on`=1 while idle, where `x_hi<=x_lo`, `y_hi<=y_lo`, `x_hi>178` or `y_hi>128`, raises `reject` for exactly the next cycle and sends nothing; `busy` stays 0.
- R4: An accepted request produces, in this order:
  - 0x2A with `out_is_data`=0, then four bytes with `out_is_data`=1;
  - 0x2B with `out_is_data`=0, then four bytes with `out_is_data`=1;
  - 0x2C with `out_is_data`=0;
  - the data bytes with `out_is_data`=1.
- R5: The four column arguments are the high byte then the low byte of floor(x_lo/3), followed by the high byte then the low byte of ceil(x_hi/3)-1.
- R6: The four row arguments are the high byte then the low byte of y_lo, followed by the high byte then the low byte of y_hi-1.
- R7: Exactly (ceil(x_hi/3)-floor(x_lo/3))*(y_hi-y_lo) data bytes follow 0x2C. Each equals the source byte taken in the same handshake. In the data phase `src_ready` equals `out_ready` and `out_valid` equals `src_valid`.
- R8: `busy` is 1 from the cycle after an accepted `start` through the cycle in which the last data byte transfers. It is 0 in the next cycle, and `done` pulses in that cycle.
- R9: A `start` while `busy` is 1 is ignored; the running flush completes unchanged.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte` and `out_is_data` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse for a flush |
| panel_on | input | 1 | Panel active; requests are dropped when 0 |
| x_lo | input | 8 | Left pixel column, inclusive |
| y_lo | input | 8 | Top line, inclusive |
| x_hi | input | 8 | Right pixel column, exclusive |
| y_hi | input | 8 | Bottom line, exclusive |
| busy | output | 1 | Flush in progress |
| reject | output | 1 | One-cycle pulse: rectangle refused |
| done | output | 1 | One-cycle pulse: flush completed |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_byte | output | 8 | Command, argument or pixel byte |
| out_is_data | output | 1 | 0 = command byte, 1 = argument or data byte |
| src_valid | input | 1 | Pixel source has a byte |
| src_byte | input | 8 | Packed pixel byte from source |
| src_ready | output | 1 | Controller takes the source byte |

## Verification
The hardest case to reach is a stream in which both handshakes stall independently. In that case the source drops `src_valid` while the output is ready, or the output withholds `out_ready` while a source byte waits. This is the case where a miscounted or duplicated byte would hide. The stimulus reaches it with a pseudo-random stall mode that gates both signals from a bench shift register. The source side keeps to the rule that a valid byte stays until taken. The mode runs on an unaligned window and on the full panel, where the right edge rounds past the panel width to byte 59. Single-byte windows in both far corners and a second `start` landing mid-stream complete the edge conditions.

// File: rtl/flush_pkg.sv
package flush_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COL_CMD,
        ST_COL_ARG,
        ST_ROW_CMD,
        ST_ROW_ARG,
        ST_MEM_CMD,
        ST_STREAM
    } flush_state_t;

    localparam logic [7:0] OP_COL_WIN = 8'h2A;
    localparam logic [7:0] OP_ROW_WIN = 8'h2B;
    localparam logic [7:0] OP_MEM_WR  = 8'h2C;
    localparam int         ARG_BYTES  = 4;
    localparam int         ADDR_W     = 16;
endpackage

// File: rtl/rect_align.sv
module rect_align #(
    parameter int PANEL_W      = 178,
    parameter int PANEL_H      = 128,
    parameter int PIX_PER_BYTE = 3,
    parameter int CW           = 8,
    parameter int NW           = 13
) (
    input  logic [CW-1:0]                  x_lo,
    input  logic [CW-1:0]                  y_lo,
    input  logic [CW-1:0]                  x_hi,
    input  logic [CW-1:0]                  y_hi,
    output logic                           in_range,
    output logic [flush_pkg::ADDR_W-1:0]   col_first,
    output logic [flush_pkg::ADDR_W-1:0]   col_last,
    output logic [flush_pkg::ADDR_W-1:0]   row_first,
    output logic [flush_pkg::ADDR_W-1:0]   row_last,
    output logic [NW-1:0]                  total
);
    localparam int AW = flush_pkg::ADDR_W;
    localparam logic [AW-1:0] PPB  = AW'(PIX_PER_BYTE);
    localparam logic [AW-1:0] PW   = AW'(PANEL_W);
    localparam logic [AW-1:0] PH   = AW'(PANEL_H);
    localparam logic [AW-1:0] RUP  = AW'(PIX_PER_BYTE - 1);

    logic [AW-1:0] xl, xh, yl, yh, col_end_x;

    always_comb begin
        xl        = AW'(x_lo);
        xh        = AW'(x_hi);
        yl        = AW'(y_lo);
        yh        = AW'(y_hi);
        in_range  = (xh > xl) && (yh > yl) && (xh <= PW) && (yh <= PH);
        col_first = xl / PPB;
        col_end_x = (xh + RUP) / PPB;
        col_last  = col_end_x - AW'(1);
        row_first = yl;
        row_last  = yh - AW'(1);
        total     = NW'(col_end_x - col_first) * NW'(yh - yl);
    end
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int NW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [NW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec && remain != '0)
            remain <= remain - NW'(1);
    end

    assign last = (remain == NW'(1));
endmodule

// File: rtl/flush_fsm.sv
module flush_fsm
    import flush_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         req_ok,
    input  logic         out_ready,
    input  logic         src_valid,
    input  logic         cnt_last,
    output flush_state_t state,
    output logic [1:0]   arg_idx,
    output logic         take,
    output logic         busy,
    output logic         reject,
    output logic         done,
    output logic         out_valid,
    output logic         out_is_data,
    output logic         src_ready,
    output logic         cnt_dec
);
    flush_state_t nxt;
    logic         xfer;
    logic         last_arg;

    assign xfer     = out_valid && out_ready;
    assign last_arg = (arg_idx == 2'(ARG_BYTES - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req && req_ok)       nxt = ST_COL_CMD;
            ST_COL_CMD: if (xfer)                nxt = ST_COL_ARG;
            ST_COL_ARG: if (xfer && last_arg)    nxt = ST_ROW_CMD;
            ST_ROW_CMD: if (xfer)                nxt = ST_ROW_ARG;
            ST_ROW_ARG: if (xfer && last_arg)    nxt = ST_MEM_CMD;
            ST_MEM_CMD: if (xfer)                nxt = ST_STREAM;
            ST_STREAM:  if (xfer && cnt_last)    nxt = ST_IDLE;
            default:                             nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            arg_idx <= 2'd0;
            reject  <= 1'b0;
            done    <= 1'b0;
        end else begin
            state   <= nxt;
            if ((state == ST_COL_ARG || state == ST_ROW_ARG) && xfer)
                arg_idx <= arg_idx + 2'd1;
            else if (state != ST_COL_ARG && state != ST_ROW_ARG)
                arg_idx <= 2'd0;
            reject  <= (state == ST_IDLE) && req && !req_ok;
            done    <= (state == ST_STREAM) && xfer && cnt_last;
        end
    end

    always_comb begin
        take        = 1'b0;
        busy        = 1'b1;
        out_valid   = 1'b0;
        out_is_data = 1'b0;
        src_ready   = 1'b0;
        cnt_dec     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                take = req && req_ok;
            end
            ST_COL_CMD, ST_ROW_CMD, ST_MEM_CMD: begin
                out_valid = 1'b1;
            end
            ST_COL_ARG, ST_ROW_ARG: begin
                out_valid   = 1'b1;
                out_is_data = 1'b1;
            end
            ST_STREAM: begin
                out_valid   = src_valid;
                out_is_data = 1'b1;
                src_ready   = out_ready;
                cnt_dec     = src_valid && out_ready;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/rect_flush_ctrl.sv
module rect_flush_ctrl
    import flush_pkg::*;
#(
    parameter int PANEL_W      = 178,
    parameter int PANEL_H      = 128,
    parameter int PIX_PER_BYTE = 3,
    parameter int CW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          panel_on,
    input  logic [CW-1:0] x_lo,
    input  logic [CW-1:0] y_lo,
    input  logic [CW-1:0] x_hi,
    input  logic [CW-1:0] y_hi,
    output logic          busy,
    output logic          reject,
    output logic          done,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_byte,
    output logic          out_is_data,
    input  logic          src_valid,
    input  logic [7:0]    src_byte,
    output logic          src_ready
);
    localparam int ROW_BYTES = (PANEL_W + PIX_PER_BYTE - 1) / PIX_PER_BYTE;
    localparam int NW        = $clog2(ROW_BYTES * PANEL_H + 1);
    localparam int AW        = ADDR_W;

    logic          in_range;
    logic [AW-1:0] al_cf, al_cl, al_rf, al_rl;
    logic [NW-1:0] al_total;
    logic [AW-1:0] win_cf, win_cl, win_rf, win_rl;
    logic [NW-1:0] win_total;
    flush_state_t  state;
    logic [1:0]    arg_idx;
    logic          take, cnt_last, cnt_dec;

    rect_align #(
        .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .PIX_PER_BYTE(PIX_PER_BYTE),
        .CW(CW), .NW(NW)
    ) u_align (
        .x_lo(x_lo), .y_lo(y_lo), .x_hi(x_hi), .y_hi(y_hi),
        .in_range(in_range),
        .col_first(al_cf), .col_last(al_cl),
        .row_first(al_rf), .row_last(al_rl),
        .total(al_total)
    );

    flush_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(start && panel_on), .req_ok(in_range),
        .out_ready(out_ready), .src_valid(src_valid), .cnt_last(cnt_last),
        .state(state), .arg_idx(arg_idx), .take(take),
        .busy(busy), .reject(reject), .done(done),
        .out_valid(out_valid), .out_is_data(out_is_data),
        .src_ready(src_ready), .cnt_dec(cnt_dec)
    );

    xfer_counter #(.NW(NW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(take), .load_val(al_total),
        .dec(cnt_dec), .last(cnt_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cf    <= '0;
            win_cl    <= '0;
            win_rf    <= '0;
            win_rl    <= '0;
            win_total <= '0;
        end else if (take) begin
            win_cf    <= al_cf;
            win_cl    <= al_cl;
            win_rf    <= al_rf;
            win_rl    <= al_rl;
            win_total <= al_total;
        end
    end

    function automatic logic [7:0] arg_pick(input logic [AW-1:0] first,
                                            input logic [AW-1:0] last,
                                            input logic [1:0]    idx);
        unique case (idx)
            2'd0:    arg_pick = first[15:8];
            2'd1:    arg_pick = first[7:0];
            2'd2:    arg_pick = last[15:8];
            default: arg_pick = last[7:0];
        endcase
    endfunction

    always_comb begin
        unique case (state)
            ST_COL_CMD: out_byte = OP_COL_WIN;
            ST_COL_ARG: out_byte = arg_pick(win_cf, win_cl, arg_idx);
            ST_ROW_CMD: out_byte = OP_ROW_WIN;
            ST_ROW_ARG: out_byte = arg_pick(win_rf, win_rl, arg_idx);
            ST_MEM_CMD: out_byte = OP_MEM_WR;
            ST_STREAM:  out_byte = src_byte;
            default:    out_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/flush_chk.sv
module flush_chk #(
    parameter int NW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          reject,
    input logic          done,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_byte,
    input logic          out_is_data,
    input logic          src_ready,
    input logic [NW-1:0] win_total
);
    logic          in_data;
    logic [NW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_data <= 1'b0;
            seen    <= '0;
        end else if (out_valid && out_ready && !out_is_data && out_byte == 8'h2C) begin
            in_data <= 1'b1;
            seen    <= '0;
        end else if (done) begin
            in_data <= 1'b0;
        end else if (in_data && out_valid && out_ready && out_is_data) begin
            seen    <= seen + NW'(1);
        end
    end

    // R3
    reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy && !out_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !src_ready);

    // R4
    first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> out_valid && !out_is_data && out_byte == 8'h2C - 8'h02);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_is_data));

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    // R7
    byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> seen == win_total);
endmodule

bind rect_flush_ctrl flush_chk #(.NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .reject(reject), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_is_data(out_is_data), .src_ready(src_ready), .win_total(win_total)
);

// File: tb/rect_flush_ctrl_test.sv
module rect_flush_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       panel_on = 1'b1;
    logic [7:0] x_lo = 8'd0, y_lo = 8'd0, x_hi = 8'd0, y_hi = 8'd0;
    logic       busy, reject, done, out_valid, out_is_data, src_ready;
    logic       out_ready = 1'b1;
    logic       src_valid = 1'b1;
    logic [7:0] out_byte, src_byte;

    int checks = 0;
    int fails  = 0;
    int src_cnt = 0;
    bit src_adv = 1'b0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state; entry = {kind[1:0], a0, byte}
    logic [10:0] expq[$];
    bit mb = 0, mrej = 0, mdone = 0;

    always #10 clk = ~clk;

    rect_flush_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .panel_on(panel_on),
        .x_lo(x_lo), .y_lo(y_lo), .x_hi(x_hi), .y_hi(y_hi),
        .busy(busy), .reject(reject), .done(done),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_is_data(out_is_data), .src_valid(src_valid), .src_byte(src_byte),
        .src_ready(src_ready)
    );

    function automatic logic [7:0] pix(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    assign src_byte = pix(src_cnt);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0: return "R4 command";
            2'd1: return "R5 column arg";
            2'd2: return "R6 row arg";
            default: return "R7 data";
        endcase
    endfunction

    function automatic bit rect_ok(input int a, input int b, input int c, input int d);
        return (c > a) && (d > b) && (c <= 178) && (d <= 128);
    endfunction

    task automatic push_flush(input int a, input int b, input int c, input int d);
        int cs, ce, n;
        cs = a / 3;
        ce = (c + 2) / 3;
        n  = (ce - cs) * (d - b);
        expq.push_back({2'd0, 1'b0, 8'h2A});
        expq.push_back({2'd1, 1'b1, 8'(cs >> 8)});
        expq.push_back({2'd1, 1'b1, 8'(cs)});
        expq.push_back({2'd1, 1'b1, 8'((ce - 1) >> 8)});
        expq.push_back({2'd1, 1'b1, 8'(ce - 1)});
        expq.push_back({2'd0, 1'b0, 8'h2B});
        expq.push_back({2'd2, 1'b1, 8'(b >> 8)});
        expq.push_back({2'd2, 1'b1, 8'(b)});
        expq.push_back({2'd2, 1'b1, 8'((d - 1) >> 8)});
        expq.push_back({2'd2, 1'b1, 8'(d - 1)});
        expq.push_back({2'd0, 1'b0, 8'h2C});
        for (int k = 0; k < n; k++) expq.push_back({2'd3, 1'b1, pix(k)});
    endtask

    // reference model, evaluated mid-cycle on values used at the next edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit xfer, emptied, acc;
            logic [10:0] f;
            chk(busy == mb, "R8 busy", busy, mb);
            chk(reject == mrej, "R3 reject", reject, mrej);
            chk(done == mdone, "R8 done", done, mdone);
            if (!mb) chk(!out_valid && !src_ready, "R2 idle quiet", {out_valid, src_ready}, 0);
            xfer = out_valid && out_ready;
            emptied = 0;
            if (xfer) begin
                if (expq.size() == 0) begin
                    chk(0, "R4 unexpected byte", out_byte, 0);
                end else begin
                    f = expq.pop_front();
                    chk({out_is_data, out_byte} == f[8:0], kind_tag(f[10:9]),
                        {out_is_data, out_byte}, f[8:0]);
                    emptied = (expq.size() == 0);
                end
            end
            if (mb && expq.size() > 0 && expq[0][10:9] == 2'd3 && out_is_data)
                chk(src_ready == out_ready && out_valid == src_valid, "R7 handshake",
                    {src_ready, out_valid}, {out_ready, src_valid});
            acc  = start && panel_on && !mb;
            mrej = acc && !rect_ok(x_lo, y_lo, x_hi, y_hi);
            mdone = xfer && emptied;
            if (acc && rect_ok(x_lo, y_lo, x_hi, y_hi)) begin
                push_flush(x_lo, y_lo, x_hi, y_hi);
                mb = 1;
            end else if (mdone) begin
                mb = 0;
            end
            src_adv = src_valid && src_ready;
        end
    end

    // handshake driver, shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (src_adv) src_cnt++;
        src_adv = 0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? lfsr[3] : 1'b1;
        if (!(src_valid && !src_ready))
            src_valid = stall_en ? lfsr[7] : 1'b1;
    end

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic pulse(input int a, input int b, input int c, input int d);
        x_lo = 8'(a); y_lo = 8'(b); x_hi = 8'(c); y_hi = 8'(d);
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic run_flush(input int a, input int b, input int c, input int d);
        src_cnt = 0;
        pulse(a, b, c, d);
        tick();
        while (busy) tick();
        tick();
        chk(expq.size() == 0, "R7 all bytes sent", expq.size(), 0);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        join_none

        #1;
        // R1 reset state
        chk({busy, reject, done, out_valid, src_ready} == 5'b0, "R1 reset outputs",
            {busy, reject, done, out_valid, src_ready}, 0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk({busy, reject, done, out_valid, src_ready} == 5'b0, "R1 after reset",
            {busy, reject, done, out_valid, src_ready}, 0);

        // R4 R5 R6 R7: unaligned window 4..10 x 5..9 -> cols 1..3, 12 bytes
        run_flush(4, 5, 10, 9);
        // single byte in both corners
        run_flush(0, 0, 1, 1);
        run_flush(177, 127, 178, 128);

        // R3 rejects
        pulse(5, 0, 5, 10);  tick(); tick();
        pulse(0, 9, 3, 9);   tick(); tick();
        pulse(0, 0, 179, 4); tick(); tick();
        pulse(0, 0, 6, 129); tick(); tick();
        chk(expq.size() == 0 && !busy, "R3 nothing sent", expq.size(), 0);

        // R2 inactive panel
        panel_on = 1'b0;
        pulse(0, 0, 9, 9); tick(); tick();
        chk(!busy && !out_valid, "R2 inactive ignored", busy, 0);
        panel_on = 1'b1;

        // R10 backpressure on both sides
        stall_en = 1'b1;
        run_flush(2, 3, 20, 11);
        run_flush(0, 0, 178, 128);

        // R9 second start mid-flush
        stall_en = 1'b0;
        src_cnt = 0;
        pulse(30, 40, 60, 50);
        repeat (20) tick();
        pulse(0, 0, 3, 3);
        while (busy) tick();
        tick();
        chk(expq.size() == 0 && !busy, "R9 ignored restart", expq.size(), 0);

        repeat (4) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule